// File: doc/BRIEF.md
# Register Access Guard Sequencer

This block sits between a requester that issues single register accesses (offset, read or write, write data) and a downstream register bus. On the affected early silicon revision, touching certain internal registers without surrounding traffic can hang the register path. The sequencer therefore brackets each guarded access with dummy reads. The addresses of those reads depend on the target offset: one dummy read comes before the real access and one or two come after it. Only when the last dummy read has completed does the block present a done pulse and the read data.

Whether an access is guarded is decided when the request is accepted. Both the revision input and the offset take part in that decision. On any other revision, and for offsets at or above the guard limit, the block forwards only the requested access. Dummy reads never write, and their return data never reaches the requester.

Top module: `regguard_seq`

## Requirements
- R1: When `rev` differs from the affected revision code (default 4'h1), the request produces exactly one downstream access: the requested offset, direction and write data.
- R2: With the affected revision, an offset at or above the guard limit (default 20'h45000) produces exactly one downstream access. Offset 20'h44FF8 is still guarded.
- R3: A guarded access to offset 20'h00000 or 20'h00080 is preceded by a dummy read of offset 20'h000C0.
- R4: A guarded access to offset 20'h00148 or 20'h00200 is preceded by a dummy read of offset 20'h00028.
- R5: Any other guarded offset is preceded by a dummy read of offset 20'h00158.
- R6: A guarded access to offset 20'h00100 is followed by a dummy read of 20'h00038, which comes before the closing dummy read.
- R7: Every guarded access ends with a dummy read of offset 20'h0B050. A guarded request therefore makes 3 downstream accesses, or 4 when R6 applies.
- R8: Dummy accesses are always reads (`bus_write` low). A requested write appears on the bus once, as a write carrying `req_wdata`.
- R9: `rsp_rdata` takes the `bus_rdata` returned for the real read only. Data returned by dummy reads is discarded. A write request leaves `rsp_rdata` unchanged.
- R10: `req_ready` is low from the cycle after acceptance until the request is done. `done` is a single-cycle pulse, one per request, raised in the cycle after the final downstream access completes.
- R11: Downstream handshake rules:
  - Once `bus_valid` is raised, it stays high with stable address and direction until `bus_ready`.
  - A write completes on its handshake.
  - A read completes when `bus_rvalid` arrives.
- R12: After synchronous reset, `req_ready` is high and `bus_valid`, `done` and `rsp_rdata` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rev | input | REV_W (4) | Silicon revision code, sampled at acceptance |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Block idle and able to accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (20) | Register offset from the block base, 64-bit word aligned |
| req_wdata | input | DATA_W (64) | Write data |
| done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W (64) | Read data of the last real read |
| bus_valid | output | 1 | Downstream access valid |
| bus_ready | input | 1 | Downstream accepts the access |
| bus_write | output | 1 | Downstream direction, 1 = write |
| bus_addr | output | ADDR_W (20) | Downstream offset |
| bus_wdata | output | DATA_W (64) | Downstream write data (zero on reads) |
| bus_rvalid | input | 1 | Downstream read data valid |
| bus_rdata | input | DATA_W (64) | Downstream read data |

## Verification
The bench builds the block with its default parameters: 20-bit offsets, 64-bit data, revision code 4'h1 and the 20'h45000 guard limit. With these values the bench can reach every lead-read selection, the extra trailing read at 20'h00100, and both sides of the guard limit (20'h44FF8 and 20'h45000).

The downstream model varies `bus_ready` and the read-response delay from an LFSR. This exercises both stall paths, and each read returns data that depends on its address, so any leak of dummy-read data into `rsp_rdata` would be visible.

// File: rtl/regguard_pkg.sv
// regguard_pkg: shared constants and the sequencer state type.
// Assumes at most one lead read, one real access and two tail reads.
package regguard_pkg;
    localparam int MAX_HOPS   = 4;
    localparam int HOP_IDX_W  = $clog2(MAX_HOPS);
    localparam int HOP_CNT_W  = $clog2(MAX_HOPS + 1);

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ISSUE   = 2'd1,
        ST_WAIT_RD = 2'd2,
        ST_DONE    = 2'd3
    } seq_state_e;
endpackage

// File: rtl/regguard_plan.sv
// regguard_plan: combinational planner. From the requested offset and the
// revision code it builds the ordered list of downstream hops (offset and a
// flag marking the real access) and the hop count.
// Assumes the caller samples the plan in the cycle the request is accepted.
module regguard_plan
    import regguard_pkg::*;
#(
    parameter int                 ADDR_W         = 20,
    parameter int                 REV_W          = 4,
    parameter logic [REV_W-1:0]   AFFECTED_REV   = 4'h1,
    parameter logic [ADDR_W-1:0]  GUARD_LIMIT    = 20'h45000,
    parameter int                 N_LEAD_A       = 2,
    parameter logic [ADDR_W-1:0]  LEAD_A_TRIGS [N_LEAD_A] = '{20'h00000, 20'h00080},
    parameter logic [ADDR_W-1:0]  LEAD_A_ADDR    = 20'h000C0,
    parameter int                 N_LEAD_B       = 2,
    parameter logic [ADDR_W-1:0]  LEAD_B_TRIGS [N_LEAD_B] = '{20'h00148, 20'h00200},
    parameter logic [ADDR_W-1:0]  LEAD_B_ADDR    = 20'h00028,
    parameter logic [ADDR_W-1:0]  LEAD_DEF_ADDR  = 20'h00158,
    parameter logic [ADDR_W-1:0]  TAIL_XTRA_TRIG = 20'h00100,
    parameter logic [ADDR_W-1:0]  TAIL_XTRA_ADDR = 20'h00038,
    parameter logic [ADDR_W-1:0]  TAIL_LAST_ADDR = 20'h0B050
) (
    input  logic [ADDR_W-1:0]                 req_addr,
    input  logic [REV_W-1:0]                  rev,
    output logic [MAX_HOPS-1:0][ADDR_W-1:0]   hop_addr,
    output logic [MAX_HOPS-1:0]               hop_real,
    output logic [HOP_CNT_W-1:0]              hop_cnt
);
    logic [N_LEAD_A-1:0] lead_a_hit;
    logic [N_LEAD_B-1:0] lead_b_hit;
    logic                guarded;
    logic                tail_xtra;
    logic [ADDR_W-1:0]   lead_addr;

    // Match the offset against each trigger of the first lead group.
    for (genvar i = 0; i < N_LEAD_A; i++) begin : g_lead_a
        assign lead_a_hit[i] = (req_addr == LEAD_A_TRIGS[i]);
    end

    // Match the offset against each trigger of the second lead group.
    for (genvar i = 0; i < N_LEAD_B; i++) begin : g_lead_b
        assign lead_b_hit[i] = (req_addr == LEAD_B_TRIGS[i]);
    end

    // Guard only the affected revision and offsets below the limit.
    assign guarded   = (rev == AFFECTED_REV) && (req_addr < GUARD_LIMIT);
    assign tail_xtra = (req_addr == TAIL_XTRA_TRIG);

    // Pick the lead read: first group, then second group, else default.
    always_comb begin
        if (|lead_a_hit)      lead_addr = LEAD_A_ADDR;
        else if (|lead_b_hit) lead_addr = LEAD_B_ADDR;
        else                  lead_addr = LEAD_DEF_ADDR;
    end

    // Lay out the hop list in issue order.
    always_comb begin
        hop_addr = '{default: TAIL_LAST_ADDR};
        hop_real = '0;
        if (!guarded) begin
            hop_addr[0] = req_addr;
            hop_real[0] = 1'b1;
            hop_cnt     = HOP_CNT_W'(1);
        end else begin
            hop_addr[0] = lead_addr;
            hop_addr[1] = req_addr;
            hop_real[1] = 1'b1;
            if (tail_xtra) begin
                hop_addr[2] = TAIL_XTRA_ADDR;
                hop_addr[3] = TAIL_LAST_ADDR;
                hop_cnt     = HOP_CNT_W'(4);
            end else begin
                hop_addr[2] = TAIL_LAST_ADDR;
                hop_cnt     = HOP_CNT_W'(3);
            end
        end
    end
endmodule

// File: rtl/regguard_ctrl.sv
// regguard_ctrl: walks a latched hop list over the downstream bus.
// Each hop is held valid until ready. A write hop completes at its
// handshake; a read hop completes when read data returns. Only the real
// hop may write and only its read data is kept. Assumes one outstanding
// downstream access at a time.
module regguard_ctrl
    import regguard_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 64
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              req_valid,
    input  logic                              req_write,
    input  logic [DATA_W-1:0]                 req_wdata,
    input  logic [MAX_HOPS-1:0][ADDR_W-1:0]   hop_addr,
    input  logic [MAX_HOPS-1:0]               hop_real,
    input  logic [HOP_CNT_W-1:0]              hop_cnt,
    output logic                              req_ready,
    output logic                              done,
    output logic [DATA_W-1:0]                 rsp_rdata,
    output logic                              bus_valid,
    input  logic                              bus_ready,
    output logic                              bus_write,
    output logic [ADDR_W-1:0]                 bus_addr,
    output logic [DATA_W-1:0]                 bus_wdata,
    input  logic                              bus_rvalid,
    input  logic [DATA_W-1:0]                 bus_rdata
);
    seq_state_e                        state;
    logic [HOP_IDX_W-1:0]              idx;
    logic [HOP_CNT_W-1:0]              cnt_q;
    logic [MAX_HOPS-1:0][ADDR_W-1:0]   addr_q;
    logic [MAX_HOPS-1:0]               real_q;
    logic                              wr_q;
    logic [DATA_W-1:0]                 wdata_q;
    logic                              last_hop;

    // Current hop is the final one of the list.
    assign last_hop = ((HOP_CNT_W'(idx) + HOP_CNT_W'(1)) == cnt_q);

    // Drive the downstream bus and the requester status from state.
    assign req_ready = (state == ST_IDLE);
    assign done      = (state == ST_DONE);
    assign bus_valid = (state == ST_ISSUE);
    assign bus_addr  = addr_q[idx];
    assign bus_write = real_q[idx] & wr_q;
    assign bus_wdata = bus_write ? wdata_q : '0;

    // Sequencer: accept, walk hops, pulse done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            idx     <= '0;
            cnt_q   <= '0;
            addr_q  <= '0;
            real_q  <= '0;
            wr_q    <= 1'b0;
            wdata_q <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        addr_q  <= hop_addr;
                        real_q  <= hop_real;
                        cnt_q   <= hop_cnt;
                        wr_q    <= req_write;
                        wdata_q <= req_wdata;
                        idx     <= '0;
                        state   <= ST_ISSUE;
                    end
                end
                ST_ISSUE: begin
                    if (bus_ready) begin
                        if (bus_write) begin
                            if (last_hop) state <= ST_DONE;
                            else          idx   <= idx + 1'b1;
                        end else begin
                            state <= ST_WAIT_RD;
                        end
                    end
                end
                ST_WAIT_RD: begin
                    if (bus_rvalid) begin
                        if (last_hop) begin
                            state <= ST_DONE;
                        end else begin
                            idx   <= idx + 1'b1;
                            state <= ST_ISSUE;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Keep read data of the real hop only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_rdata <= '0;
        end else if (state == ST_WAIT_RD && bus_rvalid && real_q[idx]) begin
            rsp_rdata <= bus_rdata;
        end
    end
endmodule

// File: rtl/regguard_seq.sv
// regguard_seq: top of the register access guard sequencer. The planner
// turns each request into a hop list; the controller issues it.
// Assumes a valid/ready request port and a downstream bus with a
// valid/ready command phase and a read-data-valid response.
module regguard_seq
    import regguard_pkg::*;
#(
    parameter int                ADDR_W       = 20,
    parameter int                DATA_W       = 64,
    parameter int                REV_W        = 4,
    parameter logic [REV_W-1:0]  AFFECTED_REV = 4'h1,
    parameter logic [ADDR_W-1:0] GUARD_LIMIT  = 20'h45000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REV_W-1:0]  rev,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              done,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              bus_valid,
    input  logic              bus_ready,
    output logic              bus_write,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_rvalid,
    input  logic [DATA_W-1:0] bus_rdata
);
    logic [MAX_HOPS-1:0][ADDR_W-1:0] hop_addr;
    logic [MAX_HOPS-1:0]             hop_real;
    logic [HOP_CNT_W-1:0]            hop_cnt;

    // Build the hop list for the pending request.
    regguard_plan #(
        .ADDR_W       (ADDR_W),
        .REV_W        (REV_W),
        .AFFECTED_REV (AFFECTED_REV),
        .GUARD_LIMIT  (GUARD_LIMIT)
    ) u_plan (
        .req_addr (req_addr),
        .rev      (rev),
        .hop_addr (hop_addr),
        .hop_real (hop_real),
        .hop_cnt  (hop_cnt)
    );

    // Issue the hop list downstream.
    regguard_ctrl #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_wdata  (req_wdata),
        .hop_addr   (hop_addr),
        .hop_real   (hop_real),
        .hop_cnt    (hop_cnt),
        .req_ready  (req_ready),
        .done       (done),
        .rsp_rdata  (rsp_rdata),
        .bus_valid  (bus_valid),
        .bus_ready  (bus_ready),
        .bus_write  (bus_write),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rvalid (bus_rvalid),
        .bus_rdata  (bus_rdata)
    );
endmodule

// File: rtl/regguard_seq_chk.sv
// regguard_seq_chk: protocol and sequencing properties of regguard_seq,
// observed at its ports only. Bound to every instance of the top.
module regguard_seq_chk #(
    parameter int                ADDR_W         = 20,
    parameter int                REV_W          = 4,
    parameter logic [REV_W-1:0]  AFFECTED_REV   = 4'h1,
    parameter logic [ADDR_W-1:0] GUARD_LIMIT    = 20'h45000,
    parameter logic [ADDR_W-1:0] TAIL_LAST_ADDR = 20'h0B050
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [ADDR_W-1:0] req_addr,
    input logic [REV_W-1:0]  rev,
    input logic              done,
    input logic              bus_valid,
    input logic              bus_ready,
    input logic              bus_write,
    input logic [ADDR_W-1:0] bus_addr
);
    logic [ADDR_W-1:0] acc_addr;
    logic              acc_bypass;
    logic [3:0]        hs_cnt;
    logic [ADDR_W-1:0] last_hs_addr;

    // Track the accepted request and the downstream handshakes it caused.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_addr     <= '0;
            acc_bypass   <= 1'b1;
            hs_cnt       <= '0;
            last_hs_addr <= '0;
        end else if (req_valid && req_ready) begin
            acc_addr   <= req_addr;
            acc_bypass <= (rev != AFFECTED_REV) || (req_addr >= GUARD_LIMIT);
            hs_cnt     <= '0;
        end else if (bus_valid && bus_ready) begin
            hs_cnt       <= hs_cnt + 4'd1;
            last_hs_addr <= bus_addr;
        end
    end

    // R8
    dummy_is_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid && bus_write |-> bus_addr == acc_addr);

    // R10
    busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> !req_ready);

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R11
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid && !bus_ready |=> bus_valid && $stable(bus_addr) && $stable(bus_write));

    // R1
    bypass_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done && acc_bypass |-> hs_cnt == 4'd1);

    // R7
    guarded_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done && !acc_bypass |-> (hs_cnt == 4'd3 || hs_cnt == 4'd4));

    // R7
    tail_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done && !acc_bypass |-> last_hs_addr == TAIL_LAST_ADDR);
endmodule

bind regguard_seq regguard_seq_chk #(
    .ADDR_W       (ADDR_W),
    .REV_W        (REV_W),
    .AFFECTED_REV (AFFECTED_REV),
    .GUARD_LIMIT  (GUARD_LIMIT)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_addr  (req_addr),
    .rev       (rev),
    .done      (done),
    .bus_valid (bus_valid),
    .bus_ready (bus_ready),
    .bus_write (bus_write),
    .bus_addr  (bus_addr)
);

// File: tb/regguard_seq_tb.sv
// regguard_seq_tb: scoreboard bench. The driver task pushes the expected
// downstream hops and response; the negedge monitor models the bus and
// compares as the design produces results.
module regguard_seq_tb;
    localparam int          CLK_PERIOD = 10;
    localparam logic [3:0]  AFF_REV    = 4'h1;
    localparam logic [3:0]  OTHER_REV  = 4'h2;

    typedef struct {
        logic [19:0] a;
        logic        w;
        logic [63:0] d;
        string       tag;
    } hop_t;

    typedef struct {
        logic [63:0] d;
        string       tag;
    } rsp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  rev = 4'h0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [19:0] req_addr = '0;
    logic [63:0] req_wdata = '0;
    logic        done;
    logic [63:0] rsp_rdata;
    logic        bus_valid;
    logic        bus_ready = 1'b0;
    logic        bus_write;
    logic [19:0] bus_addr;
    logic [63:0] bus_wdata;
    logic        bus_rvalid = 1'b0;
    logic [63:0] bus_rdata = '0;

    int n_cmp = 0;
    int n_bad = 0;
    hop_t exp_q[$];
    rsp_t rsp_q[$];
    logic [63:0] last_rd = '0;
    logic [7:0]  lfsr = 8'h5A;
    bit          rd_pend = 0;
    int          rd_wait = 0;
    logic [19:0] rd_addr = '0;
    bit          hold_pend = 0;
    logic [19:0] hold_addr = '0;
    bit          prev_done = 0;
    bit          finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    regguard_seq u_dut (
        .clk(clk), .rst_n(rst_n), .rev(rev),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .done(done), .rsp_rdata(rsp_rdata),
        .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata)
    );

    function automatic logic [63:0] resp_of(input logic [19:0] a);
        return {12'hA5C, a, 32'(a) ^ 32'h1357_9BDF};
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic push_hop(input logic [19:0] a, input logic w,
                            input logic [63:0] d, input string tag);
        hop_t h;
        h.a = a; h.w = w; h.d = d; h.tag = tag;
        exp_q.push_back(h);
    endtask

    // Driver: predict hops and response, then issue one request.
    task automatic run_req(input logic wr, input logic [19:0] a,
                           input logic [63:0] wd, input logic [3:0] rv,
                           input string tag);
        bit          g;
        logic [19:0] lead;
        rsp_t        r;
        g = (rv == AFF_REV) && (a < 20'h45000);
        if (!g) begin
            push_hop(a, wr, wd, tag);
        end else begin
            if (a == 20'h0 || a == 20'h80)        lead = 20'h000C0;
            else if (a == 20'h148 || a == 20'h200) lead = 20'h00028;
            else                                   lead = 20'h00158;
            push_hop(lead, 1'b0, '0, tag);
            push_hop(a, wr, wd, wr ? "R8" : tag);
            if (a == 20'h100) push_hop(20'h00038, 1'b0, '0, "R6");
            push_hop(20'h0B050, 1'b0, '0, "R7");
        end
        if (!wr) last_rd = resp_of(a);
        r.d = last_rd;
        r.tag = "R9";
        rsp_q.push_back(r);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd; rev = rv;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        while (!done) begin
            chk(req_ready == 1'b0, "R10", "ready while busy", 64'(req_ready), 64'd0);
            @(negedge clk);
        end
        @(negedge clk);
    endtask

    // Monitor and downstream model, all at the falling edge.
    always @(negedge clk) begin
        bit   nr;
        hop_t h;
        rsp_t r;
        if (rst_n && !finished) begin
            if (hold_pend)
                chk(bus_valid && bus_addr == hold_addr, "R11", "valid/addr held",
                    64'(bus_addr), 64'(hold_addr));
            if (bus_rvalid) bus_rvalid = 1'b0;
            if (rd_pend) begin
                rd_wait--;
                if (rd_wait == 0) begin
                    bus_rvalid = 1'b1;
                    bus_rdata  = resp_of(rd_addr);
                    rd_pend    = 0;
                end
            end
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            nr = lfsr[0] | lfsr[1];
            bus_ready = nr;
            hold_pend = bus_valid && !nr;
            hold_addr = bus_addr;
            if (bus_valid && nr) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R7", "unexpected hop", 64'(bus_addr), 64'd0);
                end else begin
                    h = exp_q.pop_front();
                    chk(bus_addr == h.a, h.tag, "hop address", 64'(bus_addr), 64'(h.a));
                    chk(bus_write == h.w, "R8", "hop direction", 64'(bus_write), 64'(h.w));
                    if (h.w) chk(bus_wdata == h.d, "R8", "write data", bus_wdata, h.d);
                end
                if (!bus_write) begin
                    rd_pend = 1;
                    rd_wait = 1 + int'(lfsr[2]);
                    rd_addr = bus_addr;
                end
            end
            if (prev_done) chk(!done, "R10", "done single cycle", 64'(done), 64'd0);
            if (done) begin
                chk(exp_q.size() == 0, "R10", "done after all hops", 64'(exp_q.size()), 64'd0);
                if (rsp_q.size() == 0) begin
                    chk(1'b0, "R10", "extra done", 64'd1, 64'd0);
                end else begin
                    r = rsp_q.pop_front();
                    chk(rsp_rdata == r.d, r.tag, "response data", rsp_rdata, r.d);
                end
            end
            prev_done = done;
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    // Stimulus.
    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1, "R12", "reset ready", 64'(req_ready), 64'd1);
        chk(bus_valid == 1'b0, "R12", "reset bus_valid", 64'(bus_valid), 64'd0);
        chk(done == 1'b0, "R12", "reset done", 64'(done), 64'd0);
        chk(rsp_rdata == '0, "R12", "reset rsp_rdata", rsp_rdata, 64'd0);

        run_req(1'b0, 20'h00000, '0, OTHER_REV, "R1");
        run_req(1'b1, 20'h00148, 64'h1111_2222_3333_4444, OTHER_REV, "R1");
        run_req(1'b0, 20'h00000, '0, AFF_REV, "R3");
        run_req(1'b1, 20'h00080, 64'hDEAD_0000_BEEF_0080, AFF_REV, "R3");
        run_req(1'b0, 20'h00148, '0, AFF_REV, "R4");
        run_req(1'b1, 20'h00200, 64'h0200_0200_0200_0200, AFF_REV, "R4");
        run_req(1'b0, 20'h00100, '0, AFF_REV, "R6");
        run_req(1'b1, 20'h00100, 64'hCAFE_F00D_0100_0100, AFF_REV, "R6");
        run_req(1'b0, 20'h01000, '0, AFF_REV, "R5");
        run_req(1'b0, 20'h44FF8, '0, AFF_REV, "R2");
        run_req(1'b0, 20'h45000, '0, AFF_REV, "R2");
        run_req(1'b1, 20'h80000, 64'h8000_0000_0000_0008, AFF_REV, "R2");
        run_req(1'b0, 20'h000C0, '0, AFF_REV, "R5");
        run_req(1'b1, 20'h00038, 64'h3838_3838_3838_3838, AFF_REV, "R5");
        run_req(1'b0, 20'h00100, '0, OTHER_REV, "R1");

        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R7", "hops left over", 64'(exp_q.size()), 64'd0);
        chk(rsp_q.size() == 0, "R10", "responses left over", 64'(rsp_q.size()), 64'd0);
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule